// File: doc/BRIEF.md
# Parallel Bit Deposit Unit

This unit scatters the low-order bits of a source word into the bit positions that a mask word selects. It scans the mask from bit 0 upward and keeps a running source index. Each time it meets a mask one, the next unused source bit is written at that position. Every position whose mask bit is zero reads as zero in the result. The operand is 64 bits wide only when the core runs in 64-bit mode and the width-select bit is set. In every other case the operation is 32 bits wide.

A request is offered with `req_valid_i` and is taken on a clock edge where `req_ready_o` is high. There is no queue. `req_ready_o` is low for the whole time a mask walk is running, and a request offered in that time is dropped, not held. The producer has to wait for `req_ready_o` before it counts a request as accepted. The result side cannot apply back-pressure. `done_o` is a single-cycle strobe, and `dest_o` and `illegal_o` hold their values until the next completion. The walk handles one mask bit per cycle and ends as soon as no mask ones remain.

Top module: `bit_deposit_unit`

## Requirements
- R1: For an accepted legal request, result bit m equals source bit k, where k is the number of ones in the effective mask below bit m, for every m where the effective mask is one. Example: mask bits 2, 3, 5 and 6 place source bits 0, 1, 2 and 3 at result bits 2, 3, 5 and 6.
- R2: Every result bit whose effective mask bit is zero is zero.
- R3: The effective width is 64 bits only when `long_mode_i`=1 and `wide_sel_i`=1. It is 32 bits for the other three combinations, so `wide_sel_i` has no effect when `long_mode_i`=0.
- R4: In 32-bit operation, result bits 63:32 are zero, and source and mask bits 63:32 have no effect on the result.
- R5: A request with a nonzero `len_field_i` completes with `illegal_o`=1 and `dest_o`=0 in the cycle after acceptance.
- R6: A request with `legacy_mode_i`=1 completes with `illegal_o`=1 and `dest_o`=0 in the cycle after acceptance.
- R7: An effective mask of all zeros gives a zero result in the cycle after acceptance. An all-ones mask returns the source unchanged within the width.
- R8: Source bits at index k and above, where k is the population count of the effective mask, have no effect on the result.
- R9: Each accepted request produces exactly one `done_o` pulse of one cycle. `req_ready_o` is low while a walk runs, and a request offered then is ignored.
- R10: When h is the highest set bit of the effective mask, `done_o` is high in the cycle after the (h+1)-th clock edge that follows the accepting edge. The latency therefore never exceeds the operand width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Unit idle; a request is taken on this edge |
| src_i | input | 64 | Source word (bits packed low) |
| mask_i | input | 64 | Deposit mask |
| wide_sel_i | input | 1 | Ask for 64-bit width |
| long_mode_i | input | 1 | Core is in 64-bit mode |
| legacy_mode_i | input | 1 | Core is in a mode where the operation is not allowed |
| len_field_i | input | 1 | Encoding vector-length field; must be zero |
| dest_o | output | 64 | Deposited result, held until the next completion |
| done_o | output | 1 | One-cycle completion strobe |
| illegal_o | output | 1 | Last completion was an illegal request |

## Verification
A wrong source index shows up as a misplaced or duplicated bit in `dest_o` at the completion strobe. A stuck walk state shows up as a `done_o` that is late or never comes, or as `req_ready_o` staying low. A position counter that is off by one moves the completion cycle. The bench therefore checks the exact completion cycle of every operation, and not only the result value. A width-decode fault shows up at the first completion, either as nonzero upper result bits or as upper mask bits being ignored when they should not be.

// File: rtl/bdep_pkg.sv
package bdep_pkg;
  typedef struct packed {
    logic illegal;
    logic wide;
  } bdep_ctl_t;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_st_e;
endpackage

// File: rtl/bdep_decode.sv
module bdep_decode
  import bdep_pkg::*;
#(
  parameter int LENW = 1
) (
  input  logic            wide_sel_i,
  input  logic            long_mode_i,
  input  logic            legacy_mode_i,
  input  logic [LENW-1:0] len_field_i,
  output bdep_ctl_t       ctl_o
);
  always_comb begin
    ctl_o.illegal = legacy_mode_i | (|len_field_i);
    ctl_o.wide    = long_mode_i & wide_sel_i;
  end
endmodule

// File: rtl/bdep_keep.sv
module bdep_keep #(
  parameter int XLEN   = 64,
  parameter int NARROW = 32
) (
  input  logic            wide_i,
  output logic [XLEN-1:0] keep_o
);
  for (genvar g = 0; g < XLEN; g++) begin : g_bit
    if (g < NARROW) begin : g_low
      assign keep_o[g] = 1'b1;
    end else begin : g_high
      assign keep_o[g] = wide_i;
    end
  end
endmodule

// File: rtl/bdep_walker.sv
module bdep_walker
  import bdep_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] mask_i,
  output logic            busy_o,
  output logic            fin_o,
  output logic [XLEN-1:0] res_o
);
  localparam int PW = $clog2(XLEN);

  walk_st_e        st;
  logic [XLEN-1:0] mask_sh, src_sh, acc;
  logic [XLEN-1:0] mask_nx, acc_nx;
  logic [PW-1:0]   pos;

  always_comb begin
    mask_nx = mask_sh >> 1;
    acc_nx  = acc;
    if (st == WALK_RUN && mask_sh[0]) acc_nx[pos] = src_sh[0];
    fin_o = (st == WALK_RUN && mask_nx == '0) ||
            (st == WALK_IDLE && load_i && mask_i == '0);
    res_o  = (st == WALK_RUN) ? acc_nx : '0;
    busy_o = (st == WALK_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= WALK_IDLE;
      mask_sh <= '0;
      src_sh  <= '0;
      acc     <= '0;
      pos     <= '0;
    end else begin
      case (st)
        WALK_IDLE: begin
          if (load_i && mask_i != '0) begin
            st      <= WALK_RUN;
            mask_sh <= mask_i;
            src_sh  <= src_i;
            acc     <= '0;
            pos     <= '0;
          end
        end
        WALK_RUN: begin
          if (mask_sh[0]) src_sh <= src_sh >> 1;
          mask_sh <= mask_nx;
          acc     <= acc_nx;
          pos     <= pos + PW'(1);
          if (mask_nx == '0) st <= WALK_IDLE;
        end
        default: st <= WALK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bit_deposit_unit.sv
module bit_deposit_unit
  import bdep_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NARROW = 32,
  parameter int LENW   = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] mask_i,
  input  logic            wide_sel_i,
  input  logic            long_mode_i,
  input  logic            legacy_mode_i,
  input  logic [LENW-1:0] len_field_i,
  output logic [XLEN-1:0] dest_o,
  output logic            done_o,
  output logic            illegal_o
);
  bdep_ctl_t       ctl;
  logic [XLEN-1:0] keep, res;
  logic            busy, fin, take, load;

  bdep_decode #(.LENW(LENW)) u_dec (
    .wide_sel_i   (wide_sel_i),
    .long_mode_i  (long_mode_i),
    .legacy_mode_i(legacy_mode_i),
    .len_field_i  (len_field_i),
    .ctl_o        (ctl)
  );

  bdep_keep #(.XLEN(XLEN), .NARROW(NARROW)) u_keep (
    .wide_i(ctl.wide),
    .keep_o(keep)
  );

  assign req_ready_o = !busy;
  assign take        = req_valid_i && req_ready_o;
  assign load        = take && !ctl.illegal;

  bdep_walker #(.XLEN(XLEN)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(load),
    .src_i (src_i & keep),
    .mask_i(mask_i & keep),
    .busy_o(busy),
    .fin_o (fin),
    .res_o (res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      dest_o    <= '0;
    end else begin
      done_o <= 1'b0;
      if (take && ctl.illegal) begin
        done_o    <= 1'b1;
        illegal_o <= 1'b1;
        dest_o    <= '0;
      end else if (fin) begin
        done_o    <= 1'b1;
        illegal_o <= 1'b0;
        dest_o    <= res;
      end
    end
  end
endmodule

// File: rtl/bdep_chk.sv
module bdep_chk #(
  parameter int XLEN   = 64,
  parameter int NARROW = 32,
  parameter int LENW   = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [XLEN-1:0] mask_i,
  input logic            wide_sel_i,
  input logic            long_mode_i,
  input logic            legacy_mode_i,
  input logic [LENW-1:0] len_field_i,
  input logic [XLEN-1:0] dest_o,
  input logic            done_o,
  input logic            illegal_o
);
  localparam int CW = $clog2(XLEN) + 2;

  logic            take, in_wide, pend, cap_wide;
  logic [XLEN-1:0] in_mask, cap_mask;
  logic [CW-1:0]   cyc;

  assign take    = req_valid_i && req_ready_o;
  assign in_wide = long_mode_i && wide_sel_i;
  assign in_mask = in_wide ? mask_i : {{(XLEN-NARROW){1'b0}}, mask_i[NARROW-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      cap_wide <= 1'b0;
      cap_mask <= '0;
      cyc      <= '0;
    end else if (take) begin
      pend     <= 1'b1;
      cap_wide <= in_wide;
      cap_mask <= in_mask;
      cyc      <= '0;
    end else begin
      if (done_o) pend <= 1'b0;
      if (pend) cyc <= cyc + CW'(1);
    end
  end

  p_clear_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !illegal_o |-> (dest_o & ~cap_mask) == '0);
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !illegal_o && !cap_wide |-> dest_o[XLEN-1:NARROW] == '0);
  p_len_illegal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && (|len_field_i) |=> done_o && illegal_o && dest_o == '0);
  p_legacy_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && legacy_mode_i |=> done_o && illegal_o && dest_o == '0);
  p_zero_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && !legacy_mode_i && len_field_i == '0 && in_mask == '0
    |=> done_o && !illegal_o && dest_o == '0);
  p_done_owned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> pend);
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !done_o |-> !req_ready_o);
  p_latency_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> cyc <= CW'(XLEN));
endmodule

bind bit_deposit_unit bdep_chk #(.XLEN(XLEN), .NARROW(NARROW), .LENW(LENW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .mask_i       (mask_i),
  .wide_sel_i   (wide_sel_i),
  .long_mode_i  (long_mode_i),
  .legacy_mode_i(legacy_mode_i),
  .len_field_i  (len_field_i),
  .dest_o       (dest_o),
  .done_o       (done_o),
  .illegal_o    (illegal_o)
);

// File: tb/sim_bit_deposit_unit.sv
module sim_bit_deposit_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] src = '0, mask = '0, dest;
  logic        wsel = 1'b0, lmode = 1'b0, legacy = 1'b0;
  logic [0:0]  lenf = '0;
  logic        done, illegal;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_deposit_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .src_i(src), .mask_i(mask), .wide_sel_i(wsel), .long_mode_i(lmode),
    .legacy_mode_i(legacy), .len_field_i(lenf), .dest_o(dest), .done_o(done),
    .illegal_o(illegal)
  );

  function automatic logic [63:0] ref_dep(logic [63:0] s, logic [63:0] m, logic w);
    logic [63:0] r = '0;
    int k = 0;
    for (int b = 0; b < (w ? 64 : 32); b++) begin
      if (m[b]) begin
        r[b] = s[k];
        k++;
      end
    end
    return r;
  endfunction

  function automatic int ref_lat(logic [63:0] m, logic w);
    int h = -1;
    for (int b = 0; b < (w ? 64 : 32); b++) if (m[b]) h = b;
    return (h < 0) ? 1 : h + 2;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [63:0] s, input logic [63:0] m, input logic ws,
                        input logic lm, input logic lg, input logic ln,
                        output logic [63:0] d, output logic il, output int lat);
    @(negedge clk);
    src = s; mask = m; wsel = ws; lmode = lm; legacy = lg; lenf = ln;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    d = dest; il = illegal;
    @(negedge clk);
    chk(!done, "R9 done one cycle", 64'(done), 64'd0);
  endtask

  task automatic legal_op(input string tag, input logic [63:0] s, input logic [63:0] m,
                          input logic ws, input logic lm);
    logic [63:0] d;
    logic il;
    int lat;
    logic w = ws & lm;
    run_op(s, m, ws, lm, 1'b0, 1'b0, d, il, lat);
    chk(d == ref_dep(s, m, w) && !il, tag, d, ref_dep(s, m, w));
    chk(lat == ref_lat(m, w), "R10 latency", 64'(lat), 64'(ref_lat(m, w)));
  endtask

  task automatic t_reset;
    chk(req_ready && !done && !illegal && dest == '0, "R9 reset state",
        {dest[60:0], req_ready, done, illegal}, 64'd4);
  endtask

  task automatic t_example;
    legal_op("R1 example", 64'hFFFF_FFFF_FFFF_FFF5, 64'h6C, 1'b0, 1'b0);
    chk(ref_dep(64'h5, 64'h6C, 1'b0) == 64'h24, "R1 model example", ref_dep(64'h5, 64'h6C, 1'b0), 64'h24);
    legal_op("R1 scattered wide", 64'h0000_0000_0000_00A5, 64'hF000_0000_0000_000F, 1'b1, 1'b1);
  endtask

  task automatic t_zero_ones;
    legal_op("R7 zero mask", 64'hDEAD_BEEF_1234_5678, 64'h0, 1'b1, 1'b1);
    legal_op("R7 ones mask wide", 64'hDEAD_BEEF_1234_5678, '1, 1'b1, 1'b1);
    legal_op("R7 ones mask narrow", 64'hDEAD_BEEF_1234_5678, '1, 1'b0, 1'b1);
    legal_op("R2 sparse mask", 64'hFFFF_FFFF_FFFF_FFFF, 64'h8421_0000_1248_0001, 1'b1, 1'b1);
  endtask

  task automatic t_width;
    legal_op("R3 legacy-width with select", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_0000_0000_0F00, 1'b1, 1'b0);
    legal_op("R3 long mode narrow", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_0000_0000_0F00, 1'b0, 1'b1);
    legal_op("R4 upper mask only", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1);
    legal_op("R4 upper source ignored", 64'hABCD_0000_0000_0003, 64'h8000_0000, 1'b0, 1'b0);
  endtask

  task automatic t_surplus;
    logic [63:0] d1, d2;
    logic il;
    int lat;
    run_op(64'h0000_0000_0000_0006, 64'h0101_0000, 1'b1, 1'b1, 1'b0, 1'b0, d1, il, lat);
    run_op(64'hFFFF_FFFF_FFFF_FFFE, 64'h0101_0000, 1'b1, 1'b1, 1'b0, 1'b0, d2, il, lat);
    chk(d1 == d2 && d1 == 64'h0100_0000, "R8 surplus source bits", d2, 64'h0100_0000);
  endtask

  task automatic t_illegal;
    logic [63:0] d;
    logic il;
    int lat;
    run_op('1, '1, 1'b1, 1'b1, 1'b0, 1'b1, d, il, lat);
    chk(il && d == '0 && lat == 1, "R5 length field", {d[62:0], il}, 64'd1);
    run_op('1, '1, 1'b0, 1'b0, 1'b1, 1'b0, d, il, lat);
    chk(il && d == '0 && lat == 1, "R6 legacy mode", {d[62:0], il}, 64'd1);
    legal_op("R5 flag clears on legal", 64'h3, 64'h3, 1'b1, 1'b1);
  endtask

  task automatic t_busy_ignore;
    int n = 0, pulses = 0, lowrdy = 0;
    logic [63:0] got = '0;
    @(negedge clk);
    src = 64'h3; mask = 64'h8000_0000_0000_0001; wsel = 1'b1; lmode = 1'b1;
    legacy = 1'b0; lenf = '0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    src = '1; mask = '1; lenf = 1'b1;
    for (int i = 0; i < 3; i++) begin
      if (!req_ready) lowrdy++;
      @(negedge clk);
    end
    req_valid = 1'b0; lenf = '0;
    n = 4;
    for (int i = 0; i < 80; i++) begin
      if (done) begin
        pulses++;
        got = dest;
        chk(n == 65, "R10 top-bit latency", 64'(n), 64'd65);
      end
      @(negedge clk);
      n++;
    end
    chk(lowrdy == 3, "R9 ready low while busy", 64'(lowrdy), 64'd3);
    chk(pulses == 1, "R9 single done", 64'(pulses), 64'd1);
    chk(got == 64'h8000_0000_0000_0001 && !illegal, "R9 stray request ignored", got, 64'h8000_0000_0000_0001);
  endtask

  task automatic t_random;
    for (int i = 0; i < 60; i++) begin
      logic [63:0] s = {$urandom, $urandom};
      logic [63:0] m = {$urandom, $urandom} & {$urandom, $urandom};
      logic ws = 1'($urandom);
      logic lm = 1'($urandom);
      legal_op("R1 random", s, m, ws, lm);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R9 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_example();
    t_zero_ones();
    t_width();
    t_surplus();
    t_illegal();
    t_busy_ignore();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule